// File: doc/BRIEF.md
# QoS-Accept-Aware Request Arbiter

This block sits on the upstream side of a link and chooses one of several pending address requests to send on. Each request carries a 4-bit QoS value and a channel bit that marks it as a read or a write. The downstream port publishes two live minimum levels, one for reads and one for writes. These levels show which QoS values it can take at the moment. A request whose QoS is below the level for its own channel is held back and never offered, so it cannot park on the link and block it.

Among the requests that pass the filter, the highest QoS wins. Equal QoS values are resolved by a rotating pointer. After each completed handshake the pointer moves to the index one past the winner, wrapping round.

Every requester and the downstream port use valid/ready handshakes. On the request side, a requester raises `req_valid[i]` and holds its fields steady until it sees `req_ready[i]`. On the downstream side, the block keeps `out_valid` and all out fields unchanged while `out_ready` is low. The block has no buffering, so back-pressure passes straight through. A request is taken only in a cycle where `out_valid` and `out_ready` are both high, and only the selected requester sees ready.

Top module: `qga_arbiter`

## Requirements
- R1: After reset, with no request valid, `out_valid` and every `req_ready` bit are low, and the tie pointer starts at index 0.
- R2: A request is eligible only when its QoS is greater than or equal to the level of its channel. A level equal to the QoS is eligible, and a level of 0 makes every request eligible. A request that is not eligible is never newly presented.
- R3: `req_write[i]`=1 marks a write, which is compared with `lvl_wr`. `req_write[i]`=0 marks a read, which is compared with `lvl_rd`. The level of one channel has no effect on requests of the other channel.
- R4: When several requests are eligible, the one with the largest QoS is presented.
- R5: Among eligible requests that share the largest QoS, the search starts at the tie pointer and goes up through the indices, wrapping round. After a handshake with index k, the pointer becomes k+1, or 0 when k is the last index.
- R6: Once `out_valid` is high and `out_ready` is low, the same request stays presented with unchanged fields in the next cycle. This holds even if the levels rise or a higher-QoS request arrives.
- R7: When no pending request is eligible and none is being held, `out_valid` is low.
- R8: `req_ready[i]` is high only in a cycle where `out_valid` and `out_ready` are both high and index i is selected. At most one bit of `req_ready` is high at a time.
- R9: `out_src` gives the index of the presented request. `out_qos`, `out_write` and `out_addr` equal that requester's fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | NUM_REQ | One bit per requester: a request is pending |
| req_ready | output | NUM_REQ | One bit per requester: its request is taken this cycle |
| req_qos | input | NUM_REQ x QOS_W | QoS value of each request |
| req_write | input | NUM_REQ | Channel of each request: 1 write, 0 read |
| req_addr | input | NUM_REQ x ADDR_W | Address of each request |
| lvl_rd | input | QOS_W | Lowest QoS the downstream read channel takes now |
| lvl_wr | input | QOS_W | Lowest QoS the downstream write channel takes now |
| out_valid | output | 1 | A request is offered downstream |
| out_ready | input | 1 | Downstream takes the offered request |
| out_src | output | IDX_W | Index of the offered request |
| out_qos | output | QOS_W | QoS of the offered request |
| out_write | output | 1 | Channel of the offered request |
| out_addr | output | ADDR_W | Address of the offered request |

## Verification
Several input patterns are used, and each one tells a different behaviour apart. Mixed channels under unequal levels show whether the filter uses the level of the right channel and treats a level equal to the QoS as a pass. A spread of QoS values with two equal maxima separates strict priority from the tie pointer. All-equal sets, applied in turn, show whether the pointer moves to the index after each winner. A stalled downstream port, with a rising level and a late higher-priority arrival, shows whether the held request really stays fixed.

// File: rtl/qga_pkg.sv
package qga_pkg;
  // channel encoding carried by each request
  typedef enum logic {
    CH_READ  = 1'b0,
    CH_WRITE = 1'b1
  } chan_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/qga_eligibility.sv
module qga_eligibility #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned QOS_W   = 4
) (
  input  logic [NUM_REQ-1:0]            valid,
  input  logic [NUM_REQ-1:0][QOS_W-1:0] qos,
  input  logic [NUM_REQ-1:0]            is_write,
  input  logic [QOS_W-1:0]              lvl_rd,
  input  logic [QOS_W-1:0]              lvl_wr,
  output logic [NUM_REQ-1:0]            elig
);
  import qga_pkg::*;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_filt
    logic [QOS_W-1:0] floor_lvl;
    // each request is compared with the level of its own channel
    assign floor_lvl = (chan_e'(is_write[g]) == CH_WRITE) ? lvl_wr : lvl_rd;
    assign elig[g]   = valid[g] && (qos[g] >= floor_lvl);
  end
endmodule

// File: rtl/qga_pick.sv
module qga_pick #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned QOS_W   = 4,
  localparam int unsigned IDX_W  = qga_pkg::idx_width(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0]            elig,
  input  logic [NUM_REQ-1:0][QOS_W-1:0] qos,
  input  logic [IDX_W-1:0]              rr_ptr,
  output logic                          any,
  output logic [IDX_W-1:0]              idx
);
  logic [QOS_W-1:0]   top_qos;
  logic [NUM_REQ-1:0] cand;

  // first pass: largest QoS among eligible requests
  always_comb begin
    top_qos = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig[i] && (qos[i] > top_qos)) top_qos = qos[i];
    end
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_cand
    assign cand[g] = elig[g] && (qos[g] == top_qos);
  end

  // second pass: rotating search from the tie pointer
  always_comb begin
    logic found;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      int j;
      j = (int'(rr_ptr) + k) % NUM_REQ;
      if (!found && cand[j]) begin
        found = 1'b1;
        idx   = IDX_W'(j);
      end
    end
  end

  assign any = |elig;
endmodule

// File: rtl/qga_arbiter.sv
module qga_arbiter #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned QOS_W   = 4,
  parameter int unsigned ADDR_W  = 16,
  localparam int unsigned IDX_W  = qga_pkg::idx_width(NUM_REQ)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_REQ-1:0]             req_valid,
  output logic [NUM_REQ-1:0]             req_ready,
  input  logic [NUM_REQ-1:0][QOS_W-1:0]  req_qos,
  input  logic [NUM_REQ-1:0]             req_write,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0] req_addr,
  input  logic [QOS_W-1:0]               lvl_rd,
  input  logic [QOS_W-1:0]               lvl_wr,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [IDX_W-1:0]               out_src,
  output logic [QOS_W-1:0]               out_qos,
  output logic                           out_write,
  output logic [ADDR_W-1:0]              out_addr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

  logic [NUM_REQ-1:0] elig;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;
  logic [IDX_W-1:0]   rr_ptr_q;
  logic               held_q;
  logic [IDX_W-1:0]   held_idx_q;
  logic [IDX_W-1:0]   sel;
  logic               fire;

  qga_eligibility #(.NUM_REQ(NUM_REQ), .QOS_W(QOS_W)) u_elig (
    .valid    (req_valid),
    .qos      (req_qos),
    .is_write (req_write),
    .lvl_rd   (lvl_rd),
    .lvl_wr   (lvl_wr),
    .elig     (elig)
  );

  qga_pick #(.NUM_REQ(NUM_REQ), .QOS_W(QOS_W)) u_pick (
    .elig   (elig),
    .qos    (req_qos),
    .rr_ptr (rr_ptr_q),
    .any    (pick_any),
    .idx    (pick_idx)
  );

  // a stalled offer is frozen; otherwise the fresh pick is shown
  assign sel       = held_q ? held_idx_q : pick_idx;
  assign out_valid = held_q || pick_any;
  assign fire      = out_valid && out_ready;

  assign out_src   = sel;
  assign out_qos   = req_qos[sel];
  assign out_write = req_write[sel];
  assign out_addr  = req_addr[sel];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_rdy
    assign req_ready[g] = fire && (sel == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_idx_q <= '0;
      rr_ptr_q   <= '0;
    end else begin
      if (fire) begin
        held_q   <= 1'b0;
        rr_ptr_q <= (sel == LAST_IDX) ? '0 : sel + 1'b1;
      end else if (out_valid) begin
        held_q     <= 1'b1;
        held_idx_q <= sel;
      end
    end
  end

  AST_ELIG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !held_q) |-> (out_qos >= (out_write ? lvl_wr : lvl_rd))); // R2

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src) && $stable(out_addr) && $stable(out_qos))); // R6

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> !out_valid); // R7

  AST_READY_NEEDS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready != '0) |-> (out_valid && out_ready)); // R8
endmodule

// File: tb/test_qga_arbiter.sv
module test_qga_arbiter;
  localparam int N  = 4;
  localparam int QW = 4;
  localparam int AW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_n;
  logic [N-1:0]           req_valid;
  logic [N-1:0]           req_ready;
  logic [N-1:0][QW-1:0]   req_qos;
  logic [N-1:0]           req_write;
  logic [N-1:0][AW-1:0]   req_addr;
  logic [QW-1:0]          lvl_rd, lvl_wr;
  logic                   out_valid, out_ready, out_write;
  logic [IW-1:0]          out_src;
  logic [QW-1:0]          out_qos;
  logic [AW-1:0]          out_addr;

  qga_arbiter i_qga_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_qos(req_qos), .req_write(req_write), .req_addr(req_addr),
    .lvl_rd(lvl_rd), .lvl_wr(lvl_wr), .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_qos(out_qos), .out_write(out_write), .out_addr(out_addr)
  );

  typedef struct { int src; int qos; int addr; int wr; } item_t;
  item_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic post(input int i, input int q, input int w, input int a);
    req_valid[i] = 1'b1;
    req_qos[i]   = QW'(q);
    req_write[i] = w[0];
    req_addr[i]  = AW'(a);
  endtask

  task automatic expect_grant(input int i);
    item_t it;
    it.src = i; it.qos = int'(req_qos[i]); it.addr = int'(req_addr[i]); it.wr = int'(req_write[i]);
    exp_q.push_back(it);
  endtask

  // one cycle: sample just before the edge, retire handshaken requests after it
  task automatic tick();
    logic [N-1:0] hs;
    @(negedge clk); #1;
    hs = req_valid & req_ready;
    @(posedge clk); #1;
    req_valid = req_valid & ~hs;
  endtask

  task automatic drain(input string req);
    for (int c = 0; c < 20 && exp_q.size() > 0; c++) tick();
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // scoreboard monitor: compares each downstream handshake with the queue head
  always begin
    @(negedge clk); #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R7 grant with nothing expected", int'(out_src), -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(int'(out_src) == it.src, "R4/R5 grant order", int'(out_src), it.src);
        check(int'(out_qos) == it.qos && int'(out_write) == it.wr, "R9 qos/channel", int'(out_qos), it.qos);
        check(int'(out_addr) == it.addr, "R9 address", int'(out_addr), it.addr);
      end
    end
  end

  initial begin
    #400000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = '0; req_qos = '0; req_write = '0; req_addr = '0;
    lvl_rd = '0; lvl_wr = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(req_ready == '0, "R1 req_ready after reset", int'(req_ready), 0);
    @(posedge clk); #1;

    // single read, level 0; pointer 0 -> 2
    post(1, 5, 0, 16'h1111); expect_grant(1);
    drain("R9 single request");

    // read level 6 blocks read qos5; write level 0 passes write qos3
    lvl_rd = 4'd6; lvl_wr = 4'd0;
    post(0, 5, 0, 16'h2000); post(1, 3, 1, 16'h2001); expect_grant(1);
    drain("R3 write passes, read held");
    tick();
    check(!out_valid, "R7 only ineligible pending", int'(out_valid), 0);
    check(req_ready == '0, "R2 ineligible not readied", int'(req_ready), 0);
    lvl_rd = 4'd5; expect_grant(0);   // equal level is eligible
    drain("R2 level equal to qos");

    // priority with a tie at 9; pointer now 1 -> order 1,3,2,0
    lvl_rd = '0;
    post(0, 2, 0, 16'h3000); post(1, 9, 0, 16'h3001);
    post(2, 7, 0, 16'h3002); post(3, 9, 0, 16'h3003);
    expect_grant(1); expect_grant(3); expect_grant(2); expect_grant(0);
    drain("R4 highest qos first");

    // all equal; pointer 1 -> 1,2,3,0
    for (int i = 0; i < N; i++) post(i, 4, i % 2, 16'h4000 + i);
    expect_grant(1); expect_grant(2); expect_grant(3); expect_grant(0);
    drain("R5 rotation from pointer");
    // pointer 1: tie between 0 and 2 -> 2 then 0
    post(0, 6, 0, 16'h5000); post(2, 6, 1, 16'h5002);
    expect_grant(2); expect_grant(0);
    drain("R5 wrap after winner");

    // stalled downstream: offer stays fixed
    out_ready = 1'b0;
    post(0, 3, 0, 16'h6000);
    tick();
    check(out_valid && out_src == 0, "R6 initial offer", int'(out_src), 0);
    lvl_rd = 4'd8; post(1, 10, 0, 16'h6001);
    for (int c = 0; c < 3; c++) begin
      tick();
      check(out_valid && out_src == 0 && out_qos == 4'd3, "R6 offer held under stall", int'(out_src), 0);
      check(req_ready == '0, "R8 no ready while stalled", int'(req_ready), 0);
    end
    expect_grant(0); expect_grant(1);
    out_ready = 1'b1;
    drain("R6 held offer completes first");

    // write level high must not block a read; low write stays hidden
    lvl_rd = '0; lvl_wr = 4'd15;
    post(3, 1, 0, 16'h7003); post(2, 1, 1, 16'h7002);
    expect_grant(3);
    drain("R3 read unaffected by write level");
    tick();
    check(!out_valid, "R7 write below level withheld", int'(out_valid), 0);
    check(req_ready == '0, "R8 no ready when idle", int'(req_ready), 0);
    lvl_wr = '0; expect_grant(2);
    drain("R2 level 0 admits all");

    tick();
    check(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule